// File: doc/BRIEF.md
# Serial Programming Read Responder

This block sits on the target side of a serial programming port that runs over SPI. The host sends instructions as frames of exactly four bytes. The responder collects the first three bytes and decodes them. During the fourth byte it shifts back the selected value. Where a read is recognised, that value comes from a small set of configuration bytes: an extended fuse byte, a high fuse byte, a low fuse byte and a bank of calibration bytes.

The configuration bytes are copied from parallel inputs while the system reset is held. After that they stay fixed. SCK, MOSI and the select input are synchronised into the system clock domain. The system clock must run at least six times faster than SCK.

During the first three byte slots, MISO echoes the byte received in the previous slot, so the host can confirm that it is aligned to frame boundaries. SPI is a fixed-rate shift with no flow control, so there is no valid/ready handshake and no back-pressure. The host paces every bit with SCK.

Top module: `spi_prog_resp`

## Requirements
- R1: While the system reset is held, or while select is low, MISO is 0. The first echo slot after select rises returns 0x00.
- R2: Bytes move MSB first in SPI mode 0. MOSI is sampled on the rising SCK edge and MISO changes only after a falling SCK edge. A frame is exactly four bytes, and the byte counter wraps back to slot one after the fourth byte.
- R3: In byte slots one to three, MISO carries the byte received in the slot before. Slot one of a frame that follows another frame in the same selection echoes the previous frame's fourth byte.
- R4: The instruction 0x50, 0x08, any third byte returns the extended fuse byte in slot four. A fuse bit reads 0 when programmed and 1 when unprogrammed, exactly as stored.
- R5: The instruction 0x58, 0x08, any third byte returns the high fuse byte in slot four.
- R6: The instruction 0x50, 0x00, any third byte returns the low fuse byte in slot four.
- R7: The instruction 0x38, 0x00, then third byte 000000bb returns calibration byte bb in slot four. Calibration byte k is taken from input bits [8k+7:8k].
- R8: The third byte of a fuse read is don't-care. Any value gives the same result.
- R9: Any other first and second byte pair returns 0xFF. So does a calibration read whose third byte has a nonzero bit above the address field. Such a frame changes no stored byte.
- R10: Dropping select at any point clears the bit and byte counters. The next frame starts at slot one.
- R11: The configuration bytes are captured only during reset. Changes on the parallel inputs after reset have no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; also loads the configuration bytes |
| prog_sel_i | input | 1 | Programming select, active high; low clears the frame counters |
| sck_i | input | 1 | SPI serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| fuse_ext_i | input | 8 | Extended fuse byte, captured during reset |
| fuse_high_i | input | 8 | High fuse byte, captured during reset |
| fuse_low_i | input | 8 | Low fuse byte, captured during reset |
| cal_bytes_i | input | 32 | Four calibration bytes, byte k in bits [8k+7:8k], captured during reset |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, four calibration bytes and four-byte frames. With four calibration bytes, all four addresses can be read, and so can a third byte that sets bit 2, just above the two-bit address field. Because frames are four bytes, the wrap from slot four back to slot one happens on every instruction. It is therefore checked back to back, together with a select drop in the middle of a byte.

// File: rtl/spi_resp_pkg.sv
package spi_resp_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t OPC_FUSE_A  = 8'h50;
  localparam byte_t OPC_FUSE_HI = 8'h58;
  localparam byte_t OPC_CALIB   = 8'h38;
  localparam byte_t SUB_EXT_HI  = 8'h08;
  localparam byte_t SUB_ZERO    = 8'h00;
  localparam byte_t RSP_NONE    = 8'hFF;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_EXT,
    CMD_HIGH,
    CMD_LOW,
    CMD_CAL
  } cmd_kind_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic sel_i,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o,
  output logic sel_o
);
  logic [STAGES-1:0] sck_sr, mosi_sr, sel_sr;
  logic              sck_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sr   <= '0;
      mosi_sr  <= '0;
      sel_sr   <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_sr   <= {sck_sr[STAGES-2:0], sck_i};
      mosi_sr  <= {mosi_sr[STAGES-2:0], mosi_i};
      sel_sr   <= {sel_sr[STAGES-2:0], sel_i};
      sck_prev <= sck_sr[STAGES-1];
    end
  end

  assign sel_o  = sel_sr[STAGES-1];
  assign mosi_o = mosi_sr[STAGES-1];
  assign rise_o = sel_o &  sck_sr[STAGES-1] & ~sck_prev;
  assign fall_o = sel_o & ~sck_sr[STAGES-1] &  sck_prev;
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_resp_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 4,
  localparam int unsigned SLOT_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1,
  localparam int unsigned BIT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  byte_t             load_i,
  output logic              byte_done_o,
  output byte_t             rx_byte_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              miso_o
);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BYTE_W - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BYTES - 1);

  logic [BIT_W-1:0]  bit_cnt;
  logic [SLOT_W-1:0] slot_q;
  byte_t             rx_sr, tx_sr, pend_q;
  logic              miso_q;

  assign rx_byte_o   = {rx_sr[BYTE_W-2:0], mosi_i};
  assign byte_done_o = rise_i && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n || !sel_i) begin
      bit_cnt <= '0;
      slot_q  <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      pend_q  <= '0;
      miso_q  <= 1'b0;
    end else begin
      if (rise_i) begin
        rx_sr   <= rx_byte_o;
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + BIT_W'(1);
        if (byte_done_o) begin
          slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + SLOT_W'(1);
          pend_q <= load_i;
        end
      end
      if (fall_i) begin
        if (bit_cnt == '0) begin
          miso_q <= pend_q[BYTE_W-1];
          tx_sr  <= {pend_q[BYTE_W-2:0], 1'b0};
        end else begin
          miso_q <= tx_sr[BYTE_W-1];
          tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign slot_o = slot_q;
  assign miso_o = miso_q;

  assert_deselect_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> (bit_cnt == '0 && slot_q == '0 && miso_q == 1'b0));
  assert_miso_moves_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !fall_i) |=> $stable(miso_q));
  assert_byte_end_realigns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && byte_done_o) |=> (bit_cnt == '0));
  assert_frame_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && byte_done_o && slot_q == LAST_SLOT) |=> (slot_q == '0));
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_resp_pkg::*;
#(
  parameter int unsigned CAL_DEPTH = 4,
  localparam int unsigned CAL_AW = (CAL_DEPTH > 1) ? $clog2(CAL_DEPTH) : 1
) (
  input  byte_t             op_i,
  input  byte_t             sub_i,
  input  byte_t             arg_i,
  output cmd_kind_e         kind_o,
  output logic [CAL_AW-1:0] cal_sel_o
);
  logic arg_hi_clear;
  assign arg_hi_clear = (arg_i[BYTE_W-1:CAL_AW] == '0);
  assign cal_sel_o    = arg_i[CAL_AW-1:0];

  always_comb begin
    kind_o = CMD_NONE;
    if (op_i == OPC_FUSE_A && sub_i == SUB_EXT_HI)
      kind_o = CMD_EXT;
    else if (op_i == OPC_FUSE_HI && sub_i == SUB_EXT_HI)
      kind_o = CMD_HIGH;
    else if (op_i == OPC_FUSE_A && sub_i == SUB_ZERO)
      kind_o = CMD_LOW;
    else if (op_i == OPC_CALIB && sub_i == SUB_ZERO && arg_hi_clear)
      kind_o = CMD_CAL;
  end
endmodule

// File: rtl/spi_fuse_bank.sv
module spi_fuse_bank
  import spi_resp_pkg::*;
#(
  parameter int unsigned CAL_DEPTH = 4,
  localparam int unsigned CAL_AW = (CAL_DEPTH > 1) ? $clog2(CAL_DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  byte_t                       ext_i,
  input  byte_t                       high_i,
  input  byte_t                       low_i,
  input  logic [CAL_DEPTH*BYTE_W-1:0] cal_i,
  input  cmd_kind_e                   kind_i,
  input  logic [CAL_AW-1:0]           cal_sel_i,
  output byte_t                       rsp_o
);
  byte_t ext_q, high_q, low_q;
  byte_t cal_q [CAL_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q  <= ext_i;
      high_q <= high_i;
      low_q  <= low_i;
    end
  end

  for (genvar g = 0; g < CAL_DEPTH; g++) begin : g_cal
    always_ff @(posedge clk) begin
      if (!rst_n) cal_q[g] <= cal_i[g*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    unique case (kind_i)
      CMD_EXT:  rsp_o = ext_q;
      CMD_HIGH: rsp_o = high_q;
      CMD_LOW:  rsp_o = low_q;
      CMD_CAL:  rsp_o = (int'(cal_sel_i) < CAL_DEPTH) ? cal_q[cal_sel_i] : RSP_NONE;
      default:  rsp_o = RSP_NONE;
    endcase
  end

  assert_fuses_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(ext_q) && $stable(high_q) && $stable(low_q)));
  assert_cal_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cal_q[0]));
endmodule

// File: rtl/spi_prog_resp.sv
module spi_prog_resp
  import spi_resp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CAL_DEPTH   = 4,
  parameter int unsigned FRAME_BYTES = 4,
  localparam int unsigned CAL_AW = (CAL_DEPTH > 1) ? $clog2(CAL_DEPTH) : 1,
  localparam int unsigned SLOT_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prog_sel_i,
  input  logic                        sck_i,
  input  logic                        mosi_i,
  output logic                        miso_o,
  input  logic [7:0]                  fuse_ext_i,
  input  logic [7:0]                  fuse_high_i,
  input  logic [7:0]                  fuse_low_i,
  input  logic [CAL_DEPTH*8-1:0]      cal_bytes_i
);
  logic              rise, fall, mosi_s, sel_s, byte_done;
  byte_t             rx_byte, op_q, sub_q, rsp, load;
  logic [SLOT_W-1:0] slot;
  cmd_kind_e         kind;
  logic [CAL_AW-1:0] cal_sel;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .mosi_i(mosi_i), .sel_i(prog_sel_i),
    .rise_o(rise), .fall_o(fall), .mosi_o(mosi_s), .sel_o(sel_s)
  );

  spi_frame_shifter #(.FRAME_BYTES(FRAME_BYTES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_s), .rise_i(rise), .fall_i(fall),
    .mosi_i(mosi_s), .load_i(load), .byte_done_o(byte_done),
    .rx_byte_o(rx_byte), .slot_o(slot), .miso_o(miso_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= '0;
      sub_q <= '0;
    end else if (byte_done) begin
      if (slot == SLOT_W'(0)) op_q  <= rx_byte;
      if (slot == SLOT_W'(1)) sub_q <= rx_byte;
    end
  end

  spi_cmd_decoder #(.CAL_DEPTH(CAL_DEPTH)) u_dec (
    .op_i(op_q), .sub_i(sub_q), .arg_i(rx_byte), .kind_o(kind), .cal_sel_o(cal_sel)
  );

  spi_fuse_bank #(.CAL_DEPTH(CAL_DEPTH)) u_bank (
    .clk(clk), .rst_n(rst_n), .ext_i(fuse_ext_i), .high_i(fuse_high_i),
    .low_i(fuse_low_i), .cal_i(cal_bytes_i), .kind_i(kind), .cal_sel_i(cal_sel),
    .rsp_o(rsp)
  );

  assign load = (slot == SLOT_W'(FRAME_BYTES - 2)) ? rsp : rx_byte;

  assert_miso_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_s && !$past(sel_s)) |-> (miso_o == 1'b0));
endmodule

// File: tb/sim_spi_prog_resp.sv
module sim_spi_prog_resp;
  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, prog_sel = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic        miso;
  logic [7:0]  f_ext, f_high, f_low;
  logic [31:0] cal;
  exp_t        sb[$];
  int          checks = 0, fails = 0;
  logic [7:0]  last_sent = 8'h00;
  logic [7:0]  mon_sr = 8'h00;
  int          mon_bits = 0;
  bit          done = 1'b0;

  localparam int HALF = 120;

  always #10 clk = ~clk;

  spi_prog_resp u0 (
    .clk(clk), .rst_n(rst_n), .prog_sel_i(prog_sel), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .fuse_ext_i(f_ext), .fuse_high_i(f_high), .fuse_low_i(f_low),
    .cal_bytes_i(cal)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // monitor: host samples MISO on rising SCK, compares whole bytes
  always @(posedge sck or negedge prog_sel) begin
    if (!prog_sel) begin
      mon_bits = 0;
    end else begin
      mon_sr = {mon_sr[6:0], miso};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: got %02h expected no byte", mon_sr);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, mon_sr, e.v);
        end
      end
    end
  end

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      #HALF sck = 1'b1;
      #HALF sck = 1'b0;
    end
  endtask

  task automatic select_on();
    prog_sel = 1'b1;
    last_sent = 8'h00;
    repeat (10) @(negedge clk);
  endtask

  task automatic select_off();
    prog_sel = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // driver: push expected bytes, then shift the frame out
  task automatic frame(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                       input logic [7:0] b4, input logic [7:0] rsp, input string tag,
                       input string tag1);
    exp_t e;
    e.v = last_sent; e.tag = tag1;  sb.push_back(e); // R3 echo of previous slot
    e.v = b1;        e.tag = "R2";  sb.push_back(e); // MSB-first echo of byte one
    e.v = b2;        e.tag = "R3";  sb.push_back(e);
    e.v = rsp;       e.tag = tag;   sb.push_back(e);
    send_bits(b1, 8); send_bits(b2, 8); send_bits(b3, 8); send_bits(b4, 8);
    last_sent = b4;
  endtask

  initial begin
    f_ext = 8'hFD; f_high = 8'h99; f_low = 8'hE1;
    cal = {8'h44, 8'h33, 8'h22, 8'hA7};
    repeat (5) @(negedge clk);
    check("R1", {7'd0, miso}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: inputs change after reset; reads keep captured values
    f_ext = 8'h00; f_high = 8'h00; f_low = 8'h00; cal = 32'h0;
    check("R1", {7'd0, miso}, 8'h00);
    select_on();
    check("R1", {7'd0, miso}, 8'h00);
    frame(8'h50, 8'h08, 8'h00, 8'h3C, 8'hFD, "R4", "R1");
    frame(8'h58, 8'h08, 8'h00, 8'hC3, 8'h99, "R5", "R3");
    frame(8'h50, 8'h00, 8'h00, 8'h81, 8'hE1, "R6", "R3");
    frame(8'h38, 8'h00, 8'h00, 8'h00, 8'hA7, "R7", "R3");
    frame(8'h38, 8'h00, 8'h01, 8'h00, 8'h22, "R7", "R3");
    frame(8'h38, 8'h00, 8'h02, 8'h00, 8'h33, "R7", "R3");
    frame(8'h38, 8'h00, 8'h03, 8'h00, 8'h44, "R11", "R3");
    frame(8'h50, 8'h08, 8'hFF, 8'h00, 8'hFD, "R8", "R3");
    frame(8'h58, 8'h08, 8'hA5, 8'h00, 8'h99, "R8", "R3");
    frame(8'h50, 8'h00, 8'h5A, 8'h00, 8'hE1, "R8", "R3");
    frame(8'h12, 8'h34, 8'h56, 8'h78, 8'hFF, "R9", "R3");
    frame(8'h38, 8'h00, 8'h04, 8'h00, 8'hFF, "R9", "R3");
    frame(8'h58, 8'h00, 8'h00, 8'h00, 8'hFF, "R9", "R3");
    frame(8'h58, 8'h08, 8'h00, 8'h00, 8'h99, "R9", "R3");
    // R10: abort mid-byte, then restart cleanly at slot one
    begin
      exp_t e;
      e.v = last_sent; e.tag = "R3"; sb.push_back(e);
      e.v = 8'h38;     e.tag = "R3"; sb.push_back(e);
      send_bits(8'h38, 8); send_bits(8'h00, 8); send_bits(8'h01, 3);
    end
    select_off();
    check("R10", {7'd0, miso}, 8'h00);
    select_on();
    frame(8'h50, 8'h08, 8'h00, 8'h00, 8'hFD, "R10", "R10");
    repeat (20) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: got %0d pending bytes expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule